// File: doc/BRIEF.md
# Identification-Page Write Controller for a Serial Memory Slave

This block is the slave-side logic of a serial memory that runs the command for writing its 64-byte identification page. The host lowers chip select and shifts in, most significant bit first on the rising clock edge (SPI mode 0), one instruction byte, three address bytes and one or more data bytes. The block oversamples the serial pins with its system clock. It counts bits to find byte boundaries and collects the data into a page buffer. A counter that stays inside the page places each byte, so a transfer that runs past the last byte continues from byte 0 and replaces what it wrote there.

When chip select rises, the block decides whether to start an internal write cycle. It starts one only if chip select rose on a byte boundary after at least one data byte, the write-enable latch is set, no write cycle is running, the two protect bits are not both 1, the page is not locked and the address selector bit is 0. A write cycle keeps the write-in-progress flag high for a parameterised number of system clocks. At the end it copies into the page array only the bytes received in that transfer, and it clears the write-enable latch. A rejected command leaves all state unchanged. A register array stands in for the nonvolatile page. A read-only debug port reads that array back.

Top module: `idpg_wr_ctrl`

## Requirements
- R1: After reset, status is 2'b00 (bit 0 = write in progress, bit 1 = write-enable latch) and every page byte reads 8'hFF.
- R2: A one-cycle pulse on `wren_req` sets the write-enable latch when no write cycle is running. The pulse is ignored while a write cycle is running.
- R3: An accepted command writes its data bytes to consecutive page addresses. The first address is bits [5:0] of the third address byte. Bits [7:6] of that byte and the whole first address byte are ignored.
- R4: A data byte that passes page address 63 goes to address 0. When a transfer holds more bytes than the page, later bytes overwrite earlier ones.
- R5: Page bytes not addressed in an accepted transfer keep their previous values.
- R6: Bit 2 of the second address byte (address bit 10) must be 0. If it is 1, the command is rejected. The other bits of that byte are ignored.
- R7: If chip select rises when the bit count is not a multiple of 8, or before any data byte has arrived, the command is rejected.
- R8: The command is rejected if the write-enable latch is 0, if `prot_bits` is 2'b11, or if `page_locked` is 1. A `prot_bits` value of 2'b10 does not block it.
- R9: An accepted command holds status bit 0 high for exactly `TWR_CYCLES` clocks. A command whose chip-select low period begins or ends during that time is rejected.
- R10: At the end of a write cycle the write-enable latch clears. This clear takes priority over a `wren_req` pulse in the same clock.
- R11: A first byte other than `OPCODE` (default 8'h83) makes the rest of the chip-select-low period have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data input |
| wren_req | input | 1 | One-cycle pulse that sets the write-enable latch |
| prot_bits | input | 2 | Block-protect bits. 2'b11 blocks the command |
| page_locked | input | 1 | Identification-page lock bit |
| status | output | 2 | {write-enable latch, write in progress} |
| dbg_addr | input | 6 | Debug read address into the page array |
| dbg_data | output | 8 | Page array byte at `dbg_addr` |

## Verification
Two functions can land in the same clock: the end of a write cycle, which clears the write-enable latch, and a `wren_req` pulse that tries to set the latch. The bench counts the clocks in which write-in-progress is high and drives the pulse on the last of them, so that both reach the same edge. The result is correct if the latch reads 0 on the next clock and a later pulse sets it. A second overlap is a complete command sent while a write cycle is running. The bench judges it by the page contents, which must hold only the data of the first command.

// File: rtl/idpg_pkg.sv
package idpg_pkg;

    typedef enum logic [2:0] {
        PH_OP,
        PH_AHI,
        PH_AMID,
        PH_ALO,
        PH_DATA,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic       vld;
        logic [7:0] data;
    } rx_byte_t;

    localparam int unsigned SEL_BIT = 2;   // address bit 10 inside the middle address byte
    localparam logic [7:0]  ERASED  = 8'hFF;

    function automatic logic prot_full(input logic [1:0] bp);
        return bp[1] & bp[0];
    endfunction

endpackage

// File: rtl/idpg_spi_rx.sv
module idpg_spi_rx
    import idpg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_n,
    input  logic     sck,
    input  logic     mosi,
    output logic     cs_high,
    output logic     cs_rise,
    output logic     cs_fall,
    output logic     on_boundary,
    output rx_byte_t rx
);

    logic [1:0] cs_s, sck_s, mo_s;
    logic       cs_d, sck_d;
    logic [2:0] bit_cnt;
    logic [6:0] sh;
    logic       sck_rise;

    assign cs_high     = cs_s[1];
    assign cs_rise     = cs_s[1] & ~cs_d;
    assign cs_fall     = ~cs_s[1] & cs_d;
    assign sck_rise    = sck_s[1] & ~sck_d;
    assign on_boundary = (bit_cnt == 3'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_s    <= 2'b11;
            sck_s   <= 2'b00;
            mo_s    <= 2'b00;
            cs_d    <= 1'b1;
            sck_d   <= 1'b0;
            bit_cnt <= '0;
            sh      <= '0;
            rx      <= '0;
        end else begin
            cs_s   <= {cs_s[0], cs_n};
            sck_s  <= {sck_s[0], sck};
            mo_s   <= {mo_s[0], mosi};
            cs_d   <= cs_s[1];
            sck_d  <= sck_s[1];
            rx.vld <= 1'b0;
            if (cs_s[1]) begin
                bit_cnt <= '0;
                sh      <= '0;
            end else if (sck_rise) begin
                sh      <= {sh[5:0], mo_s[1]};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    rx.vld  <= 1'b1;
                    rx.data <= {sh, mo_s[1]};
                end
            end
        end
    end

    // R7: a deselected slave restarts its bit count
    a_r7_count_cleared: assert property (@(posedge clk) disable iff (rst)
        cs_high |=> on_boundary);

endmodule

// File: rtl/idpg_frame.sv
module idpg_frame
    import idpg_pkg::*;
#(
    parameter int unsigned     PAGE_BYTES = 64,
    parameter logic [7:0]      OPCODE     = 8'h83,
    localparam int unsigned    AW         = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  rx_byte_t                rx,
    input  logic                    cs_rise,
    input  logic                    cs_fall,
    input  logic                    on_boundary,
    input  logic                    busy,
    input  logic                    wel,
    input  logic [1:0]              prot_bits,
    input  logic                    page_locked,
    output logic                    start,
    output logic [PAGE_BYTES*8-1:0] buf_flat,
    output logic [PAGE_BYTES-1:0]   buf_mask
);

    phase_e        ph;
    logic          addr_ok;
    logic          got_data;
    logic [AW-1:0] ptr;

    assign start = cs_rise && (ph == PH_DATA) && got_data && on_boundary && addr_ok
                   && wel && !busy && !prot_full(prot_bits) && !page_locked;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_OP;
            addr_ok  <= 1'b0;
            got_data <= 1'b0;
            ptr      <= '0;
            buf_flat <= '0;
            buf_mask <= '0;
        end else if (cs_fall) begin
            ph       <= busy ? PH_SKIP : PH_OP;
            addr_ok  <= 1'b0;
            got_data <= 1'b0;
            if (!busy) buf_mask <= '0;
        end else if (cs_rise) begin
            ph <= PH_OP;
        end else if (rx.vld) begin
            case (ph)
                PH_OP:   ph <= (rx.data == OPCODE) ? PH_AHI : PH_SKIP;
                PH_AHI:  ph <= PH_AMID;
                PH_AMID: begin
                    addr_ok <= ~rx.data[SEL_BIT];
                    ph      <= PH_ALO;
                end
                PH_ALO: begin
                    ptr <= rx.data[AW-1:0];
                    ph  <= PH_DATA;
                end
                PH_DATA: begin
                    buf_flat[ptr*8 +: 8] <= rx.data;
                    buf_mask[ptr]        <= 1'b1;
                    ptr                  <= ptr + AW'(1);
                    got_data             <= 1'b1;
                end
                default: ph <= ph;
            endcase
        end
    end

    // R4: the buffer pointer never leaves the page, so each data byte marks exactly one slot
    a_r4_one_slot_per_byte: assert property (@(posedge clk) disable iff (rst)
        (rx.vld && ph == PH_DATA && !cs_fall && !cs_rise) |=> buf_mask[$past(ptr)]);

endmodule

// File: rtl/idpg_array.sv
module idpg_array
    import idpg_pkg::*;
#(
    parameter int unsigned  PAGE_BYTES = 64,
    parameter int unsigned  TWR_CYCLES = 5000,
    localparam int unsigned AW         = $clog2(PAGE_BYTES),
    localparam int unsigned CW         = $clog2(TWR_CYCLES + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [PAGE_BYTES*8-1:0] buf_flat,
    input  logic [PAGE_BYTES-1:0]   buf_mask,
    input  logic [AW-1:0]           dbg_addr,
    output logic                    wip,
    output logic                    done,
    output logic [7:0]              dbg_data
);

    logic [CW-1:0] cnt;
    logic [7:0]    mem [PAGE_BYTES];

    assign done     = wip && (cnt == '0);
    assign dbg_data = mem[dbg_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wip <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            wip <= 1'b1;
            cnt <= CW'(TWR_CYCLES - 1);
        end else if (done) begin
            wip <= 1'b0;
        end else if (wip) begin
            cnt <= cnt - CW'(1);
        end
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)                      mem[g] <= ERASED;
            else if (done && buf_mask[g]) mem[g] <= buf_flat[g*8 +: 8];
        end
    end

    // R9: a running cycle holds the flag until its count is spent
    a_r9_wip_holds: assert property (@(posedge clk) disable iff (rst)
        (wip && cnt != '0) |=> wip);

endmodule

// File: rtl/idpg_wr_ctrl.sv
module idpg_wr_ctrl
    import idpg_pkg::*;
#(
    parameter int unsigned  PAGE_BYTES = 64,
    parameter logic [7:0]   OPCODE     = 8'h83,
    parameter int unsigned  TWR_CYCLES = 5000,
    localparam int unsigned AW         = $clog2(PAGE_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          sck,
    input  logic          mosi,
    input  logic          wren_req,
    input  logic [1:0]    prot_bits,
    input  logic          page_locked,
    output logic [1:0]    status,
    input  logic [AW-1:0] dbg_addr,
    output logic [7:0]    dbg_data
);

    rx_byte_t                rx;
    logic                    cs_high, cs_rise, cs_fall, on_boundary;
    logic                    start, wip, done, wel;
    logic [PAGE_BYTES*8-1:0] buf_flat;
    logic [PAGE_BYTES-1:0]   buf_mask;

    idpg_spi_rx u_rx (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .cs_high(cs_high), .cs_rise(cs_rise), .cs_fall(cs_fall),
        .on_boundary(on_boundary), .rx(rx)
    );

    idpg_frame #(.PAGE_BYTES(PAGE_BYTES), .OPCODE(OPCODE)) u_frame (
        .clk(clk), .rst(rst), .rx(rx), .cs_rise(cs_rise), .cs_fall(cs_fall),
        .on_boundary(on_boundary), .busy(wip), .wel(wel), .prot_bits(prot_bits),
        .page_locked(page_locked), .start(start), .buf_flat(buf_flat), .buf_mask(buf_mask)
    );

    idpg_array #(.PAGE_BYTES(PAGE_BYTES), .TWR_CYCLES(TWR_CYCLES)) u_array (
        .clk(clk), .rst(rst), .start(start), .buf_flat(buf_flat), .buf_mask(buf_mask),
        .dbg_addr(dbg_addr), .wip(wip), .done(done), .dbg_data(dbg_data)
    );

    always_ff @(posedge clk) begin
        if (rst)                   wel <= 1'b0;
        else if (done)             wel <= 1'b0;
        else if (wren_req && !wip) wel <= 1'b1;
    end

    assign status = {wel, wip};

    // R9: a start is never issued into a running cycle, and it raises the flag
    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        start |-> !wip);
    a_r9_start_sets_wip: assert property (@(posedge clk) disable iff (rst)
        start |=> wip);
    // R8: no write cycle without the enable latch
    a_r8_start_needs_wel: assert property (@(posedge clk) disable iff (rst)
        start |-> wel);
    // R10: the latch is clear when a cycle ends
    a_r10_wel_clear_at_end: assert property (@(posedge clk) disable iff (rst)
        $fell(wip) |-> !wel);
    // R2: only the request pulse sets the latch
    a_r2_wel_set_by_req: assert property (@(posedge clk) disable iff (rst)
        $rose(wel) |-> $past(wren_req));

endmodule

// File: tb/test_idpg_wr_ctrl.sv
module test_idpg_wr_ctrl;

    localparam int         PERIOD = 10;
    localparam int         TWR    = 600;
    localparam logic [7:0] OP     = 8'h83;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wren_req = 1'b0, page_locked = 1'b0;
    logic [1:0] prot_bits = 2'b00;
    logic [1:0] status;
    logic [5:0] dbg_addr = '0;
    logic [7:0] dbg_data;

    int errors = 0;
    int checks = 0;
    logic [7:0] model [64];

    always #(PERIOD/2) clk = ~clk;

    idpg_wr_ctrl #(.PAGE_BYTES(64), .OPCODE(OP), .TWR_CYCLES(TWR)) i_idpg_wr_ctrl (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi), .wren_req(wren_req),
        .prot_bits(prot_bits), .page_locked(page_locked), .status(status),
        .dbg_addr(dbg_addr), .dbg_data(dbg_data)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic check_page(input string tag);
        int bad = 0;
        checks++;
        for (int a = 0; a < 64; a++) begin
            @(negedge clk);
            dbg_addr = 6'(a);
            #1;
            if (dbg_data !== model[a]) begin
                if (bad == 0)
                    $display("FAIL %s: byte %0d got %0h expected %0h", tag, a, dbg_data, model[a]);
                bad++;
            end
        end
        if (bad != 0) errors++;
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            @(negedge clk); mosi = b[i];
            repeat (2) @(negedge clk);
            sck = 1'b1;
            repeat (2) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    function automatic logic [7:0] dval(input int seed, input int k);
        return 8'(seed + k * 29 + (k >> 3));
    endfunction

    task automatic frame(input logic [7:0] op, input logic [7:0] amid, input logic [7:0] alo,
                         input int n, input int seed, input int tail);
        @(negedge clk); cs_n = 1'b0;
        repeat (2) @(negedge clk);
        send_bits(op, 8);
        send_bits(8'hC7, 8);
        send_bits(amid, 8);
        send_bits(alo, 8);
        for (int k = 0; k < n; k++) send_bits(dval(seed, k), 8);
        if (tail > 0) send_bits(8'hA5, tail);
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
    endtask

    function automatic void apply(input logic [7:0] alo, input int n, input int seed);
        for (int k = 0; k < n; k++) model[(int'(alo[5:0]) + k) % 64] = dval(seed, k);
    endfunction

    task automatic settle(input string tag, input bit acc, input bit wel_before);
        int hi = 0;
        repeat (TWR + 40) begin
            @(negedge clk);
            if (status[0]) hi++;
        end
        chk({tag, " busy length"}, hi, acc ? TWR : 0);
        chk({tag, " enable latch"}, int'(status[1]), acc ? 0 : int'(wel_before));
    endtask

    task automatic pulse_wren;
        @(negedge clk); wren_req = 1'b1;
        @(negedge clk); wren_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int addrs [4] = '{0, 5, 37, 63};
        int lens  [5] = '{1, 2, 59, 64, 67};
        int seed = 3;
        int hi;
        for (int a = 0; a < 64; a++) model[a] = 8'hFF;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 status", int'(status), 0);
        check_page("R1 erased page");

        pulse_wren;
        chk("R2 latch set", int'(status), 2);

        // sweep of start address and length (R3, R4, R5, R6 don't-care bits)
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 5; j++) begin
                logic [7:0] alo = 8'(addrs[i]) | ((j % 2 == 1) ? 8'hC0 : 8'h00);
                pulse_wren;
                frame(OP, 8'hFB, alo, lens[j], seed, 0);
                apply(alo, lens[j], seed);
                settle((addrs[i] + lens[j] > 64) ? "R4 wrap" : "R3 write", 1'b1, 1'b1);
                check_page("R5 page contents");
                seed += 17;
            end
        end

        // rejections
        pulse_wren;
        frame(OP, 8'h04, 8'h10, 3, 91, 0);
        settle("R6 address bit 10 set", 1'b0, 1'b1);
        check_page("R6 page unchanged");

        frame(OP, 8'h00, 8'h10, 2, 92, 3);
        settle("R7 partial byte", 1'b0, 1'b1);
        frame(OP, 8'h00, 8'h10, 0, 93, 0);
        settle("R7 no data byte", 1'b0, 1'b1);
        check_page("R7 page unchanged");

        prot_bits = 2'b11;
        frame(OP, 8'h00, 8'h20, 2, 94, 0);
        settle("R8 protect 11", 1'b0, 1'b1);
        prot_bits = 2'b00;
        page_locked = 1'b1;
        frame(OP, 8'h00, 8'h20, 2, 95, 0);
        settle("R8 locked", 1'b0, 1'b1);
        page_locked = 1'b0;
        frame(8'h02, 8'h00, 8'h20, 2, 96, 0);
        settle("R11 other opcode", 1'b0, 1'b1);
        check_page("R8 R11 page unchanged");

        prot_bits = 2'b10;
        frame(OP, 8'h00, 8'h21, 2, 97, 0);
        apply(8'h21, 2, 97);
        settle("R8 protect 10 accepted", 1'b1, 1'b1);
        prot_bits = 2'b00;
        frame(OP, 8'h00, 8'h30, 2, 98, 0);
        settle("R8 latch clear", 1'b0, 1'b0);
        check_page("R8 page after latch tests");

        // R9: command during a running cycle; R2: request ignored while busy
        pulse_wren;
        frame(OP, 8'h00, 8'h08, 1, 99, 0);
        apply(8'h08, 1, 99);
        repeat (10) @(negedge clk);
        chk("R9 busy seen", int'(status[0]), 1);
        pulse_wren;
        frame(OP, 8'h00, 8'h09, 1, 100, 0);
        hi = 0;
        while (status[0] && hi < TWR + 10) begin @(negedge clk); hi++; end
        repeat (2) @(negedge clk);
        chk("R2 request ignored while busy", int'(status), 0);
        check_page("R9 second command rejected");

        // R10: request lands on the clock that ends the cycle
        pulse_wren;
        frame(OP, 8'h00, 8'h2A, 1, 101, 0);
        apply(8'h2A, 1, 101);
        hi = 0;
        while (hi < TWR) begin
            @(negedge clk);
            if (status[0]) hi++;
        end
        wren_req = 1'b1;
        @(negedge clk);
        wren_req = 1'b0;
        chk("R10 clear wins over request", int'(status), 0);
        pulse_wren;
        chk("R2 request after cycle", int'(status), 2);
        check_page("R10 page contents");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule